// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in first-out buffer for 9-bit words. Its write side and read side run on two free-running clocks that need not be related. The write port has two write enables. The read port has two active-low read enables. Four status outputs report the fill level: empty, full, a programmable almost-empty level and a programmable almost-full level. The empty and almost-empty outputs belong to the read clock. The full and almost-full outputs belong to the write clock. Each output is a register in the clock domain that owns it.

One input pin has two roles, and its role is chosen while reset is held. If the pin is high during reset, it acts as a second write enable, and both thresholds are fixed at 7. If the pin is low during reset, the block is in load mode. In load mode the pin marks offset-register traffic: while it is low, the FIFO neither accepts writes nor performs reads, and the thresholds come from an external offset-register block.

The data output is a register. It keeps the last word read while the FIFO is empty. An active-low output enable releases the data bus to high impedance.

Top module: `pflag_async_fifo`

## Requirements
- R1: While `rst_n` is low, the block samples `wen2_ld` on each `wclk` edge. A sampled 1 selects two-enable mode and a sampled 0 selects load mode. In two-enable mode, holding `wen2_ld` low does not stop reads.
- R2: A write happens on a rising `wclk` edge only when `wen1_n`=0, `wen2_ld`=1 and `full_n`=1. Writes are blocked while `full_n`=0, and data already stored is not overwritten.
- R3: A read happens on a rising `rclk` edge only when `ren1_n`=0, `ren2_n`=0 and `empty_n`=1. If either read enable is high, or `empty_n`=0, nothing is read.
- R4: In load mode, `wen2_ld`=0 blocks writes to the FIFO even when `wen1_n`=0. It also blocks reads even when both read enables are 0.
- R5: Words leave the FIFO in the order they were written. Once both clocks are idle, `empty_n` is 1 exactly when the FIFO holds at least one word.
- R6: `ae_n` is 0 when the FIFO holds n or fewer words. It is 1 when the FIFO holds n+1 or more words.
- R7: `af_n` is 0 when the FIFO holds DEPTH-m or more words. `full_n` is 0 only when the FIFO holds DEPTH words.
- R8: In two-enable mode, n=m=7 and the `ae_ofs` and `af_ofs` inputs are ignored. In load mode, n=`ae_ofs` and m=`af_ofs`.
- R9: After reset, `empty_n`=0, `ae_n`=0, `full_n`=1, `af_n`=1 and the data register is 0. This holds even if the FIFO held words before the reset.
- R10: While the FIFO is empty, further read attempts leave `q` holding the last word read.
- R11: When `oe_n`=1, all bits of `q` are high impedance. When `oe_n`=0, `q` shows the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset for both sides |
| d | input | DW | Write data |
| wen1_n | input | 1 | Active-low write enable |
| wen2_ld | input | 1 | Dual-role pin: second write enable, or offset-access marker in load mode |
| ren1_n | input | 1 | Active-low read enable, first of two |
| ren2_n | input | 1 | Active-low read enable, second of two |
| oe_n | input | 1 | Active-low output enable for `q` |
| ae_ofs | input | log2(DEPTH) | Almost-empty offset n, used in load mode |
| af_ofs | input | log2(DEPTH) | Almost-full offset m, used in load mode |
| q | output | DW | Registered read data, three-state |
| empty_n | output | 1 | Low when the FIFO is empty (read clock) |
| full_n | output | 1 | Low when the FIFO is full (write clock) |
| ae_n | output | 1 | Low at or below the almost-empty level (read clock) |
| af_n | output | 1 | Low at or above the almost-full level (write clock) |

## Verification
A write and a read can happen in the same instant from the two sides. This matters most at the edges: a read that frees a slot while the write side still sees the FIFO as full, and a write that lands while the read side still sees it as empty. The bench drives both ports at once with random enables on clocks of unrelated period. It decides every write or read from the flag value it samples just before the active edge. A queue model then checks every returned word, and it checks that no read is taken while the model holds nothing. After each burst both sides go idle. Once the pointers have crossed, all four flags are compared with the levels that the model count and the active thresholds call for.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;

   // Role of the dual-purpose pin, fixed while reset is held
   typedef enum logic {
      MODE_LOAD = 1'b0,
      MODE_DUAL = 1'b1
   } pin_mode_e;

   localparam int WORD_W_DEF = 9;

endpackage

// File: rtl/pflag_fifo_sync.sv
module pflag_fifo_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= din;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/pflag_fifo_wside.sv
module pflag_fifo_wside #(
   parameter int AW = 6
) (
   input  logic          wclk,
   input  logic          rst_n,
   input  logic          wr_req,
   input  logic [AW:0]   rgray_s,
   input  logic [AW-1:0] af_ofs,
   output logic          wr_go,
   output logic [AW-1:0] waddr,
   output logic [AW:0]   wgray,
   output logic          full_n,
   output logic          af_n
);

   localparam int PW = AW + 1;
   localparam logic [PW-1:0] DEPTH_P = PW'(2**AW);

   logic [PW-1:0] wbin, wbin_nxt, rbin_s, used_nxt, af_level;

   // decode the synchronized read pointer
   always_comb begin
      rbin_s[PW-1] = rgray_s[PW-1];
      for (int i = PW-2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
   end

   assign wr_go    = wr_req & full_n;
   assign wbin_nxt = wbin + PW'(wr_go);
   assign used_nxt = wbin_nxt - rbin_s;
   assign af_level = DEPTH_P - {1'b0, af_ofs};

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wbin   <= '0;
         wgray  <= '0;
         full_n <= 1'b1;
         af_n   <= 1'b1;
      end else begin
         wbin   <= wbin_nxt;
         wgray  <= wbin_nxt ^ (wbin_nxt >> 1);
         full_n <= (used_nxt != DEPTH_P);
         af_n   <= (used_nxt < af_level);
      end
   end

   assign waddr = wbin[AW-1:0];

   assert_no_overflow_R2 : assert property (@(posedge wclk) disable iff (!rst_n)
      (wbin - rbin_s) <= DEPTH_P);
   assert_full_blocks_R2 : assert property (@(posedge wclk) disable iff (!rst_n)
      !full_n |=> $stable(wbin));
   assert_af_covers_full_R7 : assert property (@(posedge wclk) disable iff (!rst_n)
      !full_n |-> !af_n);
   assert_wgray_step_R5 : assert property (@(posedge wclk) disable iff (!rst_n)
      $countones(wgray ^ $past(wgray)) <= 1);

endmodule

// File: rtl/pflag_fifo_rside.sv
module pflag_fifo_rside #(
   parameter int AW = 6
) (
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          rd_req,
   input  logic [AW:0]   wgray_s,
   input  logic [AW-1:0] ae_ofs,
   output logic          rd_go,
   output logic [AW-1:0] raddr,
   output logic [AW:0]   rgray,
   output logic          empty_n,
   output logic          ae_n
);

   localparam int PW = AW + 1;
   localparam logic [PW-1:0] DEPTH_P = PW'(2**AW);

   logic [PW-1:0] rbin, rbin_nxt, wbin_s, avail_nxt;

   // decode the synchronized write pointer
   always_comb begin
      wbin_s[PW-1] = wgray_s[PW-1];
      for (int i = PW-2; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
   end

   assign rd_go     = rd_req & empty_n;
   assign rbin_nxt  = rbin + PW'(rd_go);
   assign avail_nxt = wbin_s - rbin_nxt;

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rbin    <= '0;
         rgray   <= '0;
         empty_n <= 1'b0;
         ae_n    <= 1'b0;
      end else begin
         rbin    <= rbin_nxt;
         rgray   <= rbin_nxt ^ (rbin_nxt >> 1);
         empty_n <= (avail_nxt != '0);
         ae_n    <= (avail_nxt > {1'b0, ae_ofs});
      end
   end

   assign raddr = rbin[AW-1:0];

   assert_no_underflow_R3 : assert property (@(posedge rclk) disable iff (!rst_n)
      !empty_n |=> $stable(rbin));
   assert_in_range_R3 : assert property (@(posedge rclk) disable iff (!rst_n)
      (wbin_s - rbin) <= DEPTH_P);
   assert_ae_covers_empty_R6 : assert property (@(posedge rclk) disable iff (!rst_n)
      !empty_n |-> !ae_n);
   assert_rgray_step_R5 : assert property (@(posedge rclk) disable iff (!rst_n)
      $countones(rgray ^ $past(rgray)) <= 1);

endmodule

// File: rtl/pflag_async_fifo.sv
module pflag_async_fifo
   import pflag_fifo_pkg::*;
#(
   parameter int DW          = WORD_W_DEF,
   parameter int DEPTH       = 64,
   parameter int SYNC_STAGES = 2,
   parameter int DEF_OFS     = 7,
   localparam int AW         = $clog2(DEPTH)
) (
   input  logic          wclk,
   input  logic          rclk,
   input  logic          rst_n,
   input  logic [DW-1:0] d,
   input  logic          wen1_n,
   input  logic          wen2_ld,
   input  logic          ren1_n,
   input  logic          ren2_n,
   input  logic          oe_n,
   input  logic [AW-1:0] ae_ofs,
   input  logic [AW-1:0] af_ofs,
   output logic [DW-1:0] q,
   output logic          empty_n,
   output logic          full_n,
   output logic          ae_n,
   output logic          af_n
);

   // elaboration-time parameter checks
   if (DEPTH < 16 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be 2 or more");
   end
   if (DEF_OFS < 0 || DEF_OFS >= DEPTH) begin : g_bad_ofs
      $error("DEF_OFS must lie inside the depth");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   localparam logic [AW-1:0] DEF_OFS_V = AW'(DEF_OFS);

   pin_mode_e     wmode, rmode;
   logic          rmode_b;
   logic          wr_req, rd_req, wr_go, rd_go;
   logic [AW-1:0] waddr, raddr, ae_lim, af_lim;
   logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] q_reg;

   // pin role latched from wen2_ld while reset is held
   always_ff @(posedge wclk) begin
      if (!rst_n) wmode <= pin_mode_e'(wen2_ld);
   end

   pflag_fifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_mode_sync (
      .clk(rclk), .rst_n(rst_n), .din(wmode), .dout(rmode_b));
   assign rmode = pin_mode_e'(rmode_b);

   assign af_lim = (wmode == MODE_DUAL) ? DEF_OFS_V : af_ofs;
   assign ae_lim = (rmode == MODE_DUAL) ? DEF_OFS_V : ae_ofs;

   // same write qualifier in both modes: pin high means FIFO traffic
   assign wr_req = !wen1_n && wen2_ld;
   assign rd_req = !ren1_n && !ren2_n && !(rmode == MODE_LOAD && !wen2_ld);

   pflag_fifo_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wclk), .rst_n(rst_n), .din(rgray), .dout(rgray_s));
   pflag_fifo_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rclk), .rst_n(rst_n), .din(wgray), .dout(wgray_s));

   pflag_fifo_wside #(.AW(AW)) u_wside (
      .wclk(wclk), .rst_n(rst_n), .wr_req(wr_req), .rgray_s(rgray_s),
      .af_ofs(af_lim), .wr_go(wr_go), .waddr(waddr), .wgray(wgray),
      .full_n(full_n), .af_n(af_n));

   pflag_fifo_rside #(.AW(AW)) u_rside (
      .rclk(rclk), .rst_n(rst_n), .rd_req(rd_req), .wgray_s(wgray_s),
      .ae_ofs(ae_lim), .rd_go(rd_go), .raddr(raddr), .rgray(rgray),
      .empty_n(empty_n), .ae_n(ae_n));

   always_ff @(posedge wclk) begin
      if (wr_go) mem[waddr] <= d;
   end

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n)     q_reg <= '0;
      else if (rd_go) q_reg <= mem[raddr];
   end

   assign q = oe_n ? 'z : q_reg;

   assert_hold_when_empty_R10 : assert property (@(posedge rclk) disable iff (!rst_n)
      !empty_n |=> $stable(q_reg));
   assert_load_blocks_write_R4 : assert property (@(posedge wclk) disable iff (!rst_n)
      !wen2_ld |=> $stable(wgray));
   assert_load_blocks_read_R4 : assert property (@(posedge rclk) disable iff (!rst_n)
      (rmode == MODE_LOAD && !wen2_ld) |=> $stable(rgray));

endmodule

// File: tb/pflag_async_fifo_test.sv
`timescale 1ns/1ps
module pflag_async_fifo_test;

   localparam int DW = 9;
   localparam int DEPTH = 64;
   localparam int AW = 6;

   logic wclk = 0, rclk = 0, rst_n = 0;
   logic [DW-1:0] d = '0;
   logic wen1_n = 1, wen2_ld = 1, ren1_n = 1, ren2_n = 1, oe_n = 0;
   logic [AW-1:0] ae_ofs = 6'd20, af_ofs = 6'd30;
   wire  [DW-1:0] q;
   wire  empty_n, full_n, ae_n, af_n;

   int checks = 0, fails = 0;
   int n_cur = 7, m_cur = 7;
   bit done = 0;
   logic [DW-1:0] sb [$];

   always #10 wclk = ~wclk;   // 50 MHz
   always #17 rclk = ~rclk;   // unrelated read clock

   pflag_async_fifo #(.DW(DW), .DEPTH(DEPTH)) uut (
      .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .d(d), .wen1_n(wen1_n),
      .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n),
      .ae_ofs(ae_ofs), .af_ofs(af_ofs), .q(q), .empty_n(empty_n),
      .full_n(full_n), .ae_n(ae_n), .af_n(af_n));

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic bit exp_empty_n(int c); return c != 0; endfunction
   function automatic bit exp_ae_n(int c);    return c > n_cur; endfunction
   function automatic bit exp_full_n(int c);  return c != DEPTH; endfunction
   function automatic bit exp_af_n(int c);    return c < DEPTH - m_cur; endfunction

   task automatic settle();
      repeat (6) @(posedge wclk);
      repeat (6) @(posedge rclk);
      @(negedge rclk);
   endtask

   task automatic check_flags(string req);
      int c = sb.size();
      chk(empty_n == exp_empty_n(c), req, "empty_n", empty_n, exp_empty_n(c));
      chk(ae_n == exp_ae_n(c), req, "ae_n", ae_n, exp_ae_n(c));
      chk(full_n == exp_full_n(c), req, "full_n", full_n, exp_full_n(c));
      chk(af_n == exp_af_n(c), req, "af_n", af_n, exp_af_n(c));
   endtask

   task automatic do_reset(bit pin);
      @(negedge wclk);
      wen1_n = 1; ren1_n = 1; ren2_n = 1; wen2_ld = pin; rst_n = 0;
      repeat (4) @(posedge wclk);
      repeat (4) @(posedge rclk);
      @(negedge wclk); rst_n = 1; wen2_ld = 1;
      sb.delete();
      settle();
   endtask

   // need > 0: run until that many words accepted; else n cycles
   task automatic wr_run(int n, int pct, int need);
      int got = 0;
      for (int i = 0; (need > 0) ? (got < need) : (i < n); i++) begin
         @(negedge wclk);
         wen1_n = ($urandom % 100) >= pct;
         wen2_ld = 1;
         d = DW'($urandom);
         if (!wen1_n && full_n) begin sb.push_back(d); got++; end
         if (sb.size() > DEPTH) chk(0, "R2", "model beyond depth", sb.size(), DEPTH);
      end
      @(negedge wclk); wen1_n = 1;
   endtask

   task automatic rd_run(int n, int pct, int need);
      int got = 0;
      bit pend = 0;
      logic [DW-1:0] exp_w = '0;
      for (int i = 0; (need > 0) ? (got < need) : (i < n); i++) begin
         @(negedge rclk);
         if (pend) begin chk(q === exp_w, "R5", "read order", q, exp_w); pend = 0; end
         ren1_n = ($urandom % 100) >= pct;
         ren2_n = ($urandom % 100) >= pct;
         if (!ren1_n && !ren2_n && empty_n) begin
            if (sb.size() == 0) chk(0, "R3", "read taken with model empty", 1, 0);
            else begin exp_w = sb.pop_front(); pend = 1; got++; end
         end
      end
      @(negedge rclk);
      if (pend) chk(q === exp_w, "R5", "read order", q, exp_w);
      ren1_n = 1; ren2_n = 1;
   endtask

   initial begin
      logic [DW-1:0] last;
      void'($urandom(32'd2024));
      // ---- two-enable mode ----
      do_reset(1'b1);
      chk(empty_n == 0 && ae_n == 0, "R9", "reset empty/ae", {empty_n, ae_n}, 0);
      chk(full_n == 1 && af_n == 1, "R9", "reset full/af", {full_n, af_n}, 3);
      chk(q === 9'd0, "R9", "reset data", q, 0);
      oe_n = 1; #1;
      chk(q === 9'bz_zzzz_zzzz, "R11", "q released", $countones(q === 9'bz_zzzz_zzzz), 1);
      oe_n = 0; #1;
      chk(q === 9'd0, "R11", "q driven", q, 0);

      // R2: second enable low blocks writes
      @(negedge wclk); wen1_n = 0; wen2_ld = 0;
      repeat (6) @(negedge wclk);
      wen1_n = 1; wen2_ld = 1;
      settle(); check_flags("R2");

      // R6/R8: thresholds at 7 whatever the offset inputs say
      wr_run(0, 100, 7); settle(); check_flags("R8");
      wr_run(0, 100, 1); settle(); check_flags("R6");
      wr_run(0, 100, 48); settle(); check_flags("R7");
      wr_run(0, 100, 1); settle(); check_flags("R7");
      wr_run(0, 100, 6); settle(); check_flags("R7");
      wr_run(0, 100, 1); settle(); check_flags("R7");
      wr_run(12, 100, 0); settle(); check_flags("R2");

      // R1: pin low does not stop reads in two-enable mode
      wen2_ld = 0;
      rd_run(0, 100, 2);
      wen2_ld = 1;
      settle(); check_flags("R1");

      // R3: a single read enable does nothing
      @(negedge rclk); ren1_n = 0; ren2_n = 1;
      repeat (5) @(negedge rclk);
      ren1_n = 1; ren2_n = 0;
      repeat (5) @(negedge rclk);
      ren2_n = 1;
      settle(); check_flags("R3");

      // drain, then R10 hold
      rd_run(0, 100, sb.size()); settle(); check_flags("R5");
      last = q;
      rd_run(10, 100, 0); settle();
      chk(q === last, "R10", "hold last word", q, last);

      // concurrent random traffic crossing full and empty
      fork wr_run(900, 80, 0); rd_run(500, 40, 0); join
      settle(); check_flags("R5");
      fork wr_run(500, 30, 0); rd_run(700, 70, 0); join
      settle(); check_flags("R5");
      if (sb.size() > 0) rd_run(0, 100, sb.size());
      wr_run(0, 100, 5); settle();

      // ---- load mode, reset with words held ----
      ae_ofs = 6'd3; af_ofs = 6'd10;
      do_reset(1'b0);
      n_cur = 3; m_cur = 10;
      chk(empty_n == 0 && full_n == 1, "R9", "reset with data held", {empty_n, full_n}, 1);
      chk(q === 9'd0, "R9", "reset data load mode", q, 0);

      // R4: pin low blocks writes
      @(negedge wclk); wen1_n = 0; wen2_ld = 0;
      repeat (6) @(negedge wclk);
      wen1_n = 1; wen2_ld = 1;
      settle(); check_flags("R4");

      // R4: pin low blocks reads
      wr_run(0, 100, 1); settle();
      last = q;
      @(negedge rclk); wen2_ld = 0; ren1_n = 0; ren2_n = 0;
      repeat (6) @(negedge rclk);
      ren1_n = 1; ren2_n = 1; wen2_ld = 1;
      chk(q === last, "R4", "no read while pin low", q, last);
      settle(); check_flags("R4");
      rd_run(0, 100, 1); settle();

      // R8/R6/R7 with programmed offsets
      wr_run(0, 100, 3); settle(); check_flags("R8");
      wr_run(0, 100, 1); settle(); check_flags("R6");
      wr_run(0, 100, 49); settle(); check_flags("R7");
      wr_run(0, 100, 1); settle(); check_flags("R7");
      fork wr_run(600, 60, 0); rd_run(600, 55, 0); join
      settle(); check_flags("R5");
      rd_run(0, 100, sb.size()); settle(); check_flags("R5");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge wclk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule